// File: doc/BRIEF.md
# Read-Capture Delay Tap Sweep Calibrator

This block finds a working read-capture delay for a memory interface. When asked to calibrate, it steps a delay tap through every setting from the smallest to the largest. At each setting it drives the same tap to both byte lanes and has an external memory self-test engine run one test. The test reports an 8-bit compare count. The block notes the lowest and the highest setting that passed, and it counts the passes.

After the last setting has been tried, the block writes the midpoint of the passing window to both lanes. If no setting passed, it writes back the tap value that was present when calibration began. A one-cycle completion pulse then marks the end of calibration. At that point a flag shows whether any setting passed, and a count shows how many passed. The self-test engine and the delay line sit outside this block.

Top module: `dqs_tap_calibrator`

## Requirements
- R1: After a calibration request, exactly 2**TAP_W test runs take place, with taps 0, 1, … 63 in ascending order. Whenever the test start output is high, both lane tap outputs carry the tap under test.
- R2: The test start output stays high until a test-done input is seen. It is low in the cycle after the edge on which done is seen with start high.
- R3: While start is high, the expected-count output equals 8. A tap passes only when the 8-bit unsigned compare count equals 8 exactly. Counts of 7, 9 or 0 fail.
- R4: The first passing tap sets both the low and the high window edge. Each later pass moves only the high edge. The pass counter (TAP_W+1 bits) rises by one on each pass. The found flag is high if and only if the counter is non-zero. Counter and flag are valid while completion is high and hold until the next request.
- R5: When at least one tap passed, both lanes end at (low + high) / 2, truncated and then taken modulo 64.
- R6: When no tap passed, both lanes end at the value of the current-tap input sampled on the cycle the request was accepted. Later changes on that input have no effect.
- R7: Completion is high for exactly one cycle. It rises two clock edges after the edge that accepts the done of the tap-63 test, and the final tap is already on both lanes in that cycle.
- R8: A test-done input that arrives while start is low, including in the idle state, changes neither the lane taps nor the completion output.
- R9: While reset is applied, completion, start, found, pass count, expected count and both lanes are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cal_start_i | input | 1 | Calibration request, taken in idle |
| tap_init_i | input | TAP_W | Tap currently programmed, kept as fallback |
| cal_done_o | output | 1 | One-cycle completion pulse |
| cal_found_o | output | 1 | At least one tap passed |
| cal_pass_cnt_o | output | TAP_W+1 | Number of passing taps |
| bist_start_o | output | 1 | Self-test run request |
| bist_expect_o | output | CNT_W | Expected compare count for the run |
| bist_done_i | input | 1 | Self-test run finished |
| bist_count_i | input | CNT_W | Compare count reported by the run |
| tap0_o | output | TAP_W | Delay tap for byte lane 0 |
| tap1_o | output | TAP_W | Delay tap for byte lane 1 |

## Verification
A test run ends when start is high at an edge on which done is also seen. Start goes low in the next cycle. The next tap and start appear one edge after that, so each tap costs the self-test latency plus three cycles. The bench samples 1 ns after each rising edge and takes the start value it saw one sample earlier as the acceptance condition. It expects completion, and checks the final taps, found flag and pass count, at exactly the second sample after the tap-63 acceptance. In every other sample it expects completion to be low. It checks the lane taps against its own running tap index in every cycle in which start is high.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;
  typedef enum logic [2:0] {
    CAL_IDLE,
    CAL_SET,
    CAL_RUN,
    CAL_STOP,
    CAL_FINAL,
    CAL_DONE
  } cal_state_e;
endpackage

// File: rtl/dqs_rst_sync.sv
module dqs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dqs_cal_fsm.sv
module dqs_cal_fsm
  import dqs_cal_pkg::*;
#(
  parameter int TAP_W  = 6,
  parameter int CNT_W  = 8,
  parameter int EXPECT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_start_i,
  input  logic             bist_done_i,
  input  logic [TAP_W-1:0] tap_init_i,
  output cal_state_e       state_o,
  output logic [TAP_W-1:0] tap_idx_o,
  output logic [TAP_W-1:0] orig_tap_o,
  output logic [CNT_W-1:0] expect_o
);
  localparam logic [TAP_W-1:0] TAP_LAST = '1;
  localparam logic [CNT_W-1:0] EXP_VAL  = CNT_W'(EXPECT);

  cal_state_e       state_q, state_d;
  logic [TAP_W-1:0] tap_q, tap_d, orig_q, orig_d;
  logic [CNT_W-1:0] exp_q;
  logic             tap_en, orig_en, exp_en;

  always_comb begin
    state_d = state_q;
    tap_d   = tap_q;
    orig_d  = orig_q;
    tap_en  = 1'b0;
    orig_en = 1'b0;
    exp_en  = 1'b0;
    case (state_q)
      CAL_IDLE: if (cal_start_i) begin
        state_d = CAL_SET;
        tap_d   = '0;
        tap_en  = 1'b1;
        orig_d  = tap_init_i;
        orig_en = 1'b1;
      end
      CAL_SET: begin
        state_d = CAL_RUN;
        exp_en  = 1'b1;
      end
      CAL_RUN:  if (bist_done_i) state_d = CAL_STOP;
      CAL_STOP: begin
        if (tap_q == TAP_LAST) begin
          state_d = CAL_FINAL;
        end else begin
          state_d = CAL_SET;
          tap_d   = tap_q + 1'b1;
          tap_en  = 1'b1;
        end
      end
      CAL_FINAL: state_d = CAL_DONE;
      CAL_DONE:  state_d = CAL_IDLE;
      default:   state_d = CAL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAL_IDLE;
      tap_q   <= '0;
      orig_q  <= '0;
      exp_q   <= '0;
    end else begin
      state_q <= state_d;
      if (tap_en)  tap_q  <= tap_d;
      if (orig_en) orig_q <= orig_d;
      if (exp_en)  exp_q  <= EXP_VAL;
    end
  end

  assign state_o    = state_q;
  assign tap_idx_o  = tap_q;
  assign orig_tap_o = orig_q;
  assign expect_o   = exp_q;
endmodule

// File: rtl/dqs_win_track.sv
module dqs_win_track #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             rec_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             found_o,
  output logic [TAP_W-1:0] low_o,
  output logic [TAP_W-1:0] high_o,
  output logic [TAP_W:0]   cnt_o
);
  logic             found_q, found_d;
  logic [TAP_W-1:0] low_q, low_d, high_q, high_d;
  logic [TAP_W:0]   cnt_q, cnt_d;
  logic             upd_en;

  always_comb begin
    found_d = found_q;
    low_d   = low_q;
    high_d  = high_q;
    cnt_d   = cnt_q;
    upd_en  = clr_i | (rec_i & pass_i);
    if (clr_i) begin
      found_d = 1'b0;
      low_d   = '0;
      high_d  = '0;
      cnt_d   = '0;
    end else if (rec_i && pass_i) begin
      if (!found_q) low_d = tap_i;
      high_d  = tap_i;
      found_d = 1'b1;
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      low_q   <= '0;
      high_q  <= '0;
      cnt_q   <= '0;
    end else if (upd_en) begin
      found_q <= found_d;
      low_q   <= low_d;
      high_q  <= high_d;
      cnt_q   <= cnt_d;
    end
  end

  assign found_o = found_q;
  assign low_o   = low_q;
  assign high_o  = high_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/dqs_tap_drive.sv
module dqs_tap_drive #(
  parameter int TAP_W = 6,
  parameter int LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sweep_ld_i,
  input  logic                        final_ld_i,
  input  logic [TAP_W-1:0]            sweep_tap_i,
  input  logic                        found_i,
  input  logic [TAP_W-1:0]            low_i,
  input  logic [TAP_W-1:0]            high_i,
  input  logic [TAP_W-1:0]            orig_i,
  output logic [LANES-1:0][TAP_W-1:0] lanes_o
);
  logic [TAP_W:0]   sum;
  logic [TAP_W-1:0] centre, final_tap, lane_d;
  logic             lane_en;

  always_comb begin
    sum       = {1'b0, low_i} + {1'b0, high_i};
    centre    = sum[TAP_W:1];
    final_tap = found_i ? centre : orig_i;
    lane_d    = final_ld_i ? final_tap : sweep_tap_i;
    lane_en   = sweep_ld_i | final_ld_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [TAP_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_en) lane_q <= lane_d;
    end
    assign lanes_o[g] = lane_q;
  end
endmodule

// File: rtl/dqs_tap_calibrator.sv
module dqs_tap_calibrator
  import dqs_cal_pkg::*;
#(
  parameter int TAP_W  = 6,
  parameter int CNT_W  = 8,
  parameter int EXPECT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_start_i,
  input  logic [TAP_W-1:0] tap_init_i,
  output logic             cal_done_o,
  output logic             cal_found_o,
  output logic [TAP_W:0]   cal_pass_cnt_o,
  output logic             bist_start_o,
  output logic [CNT_W-1:0] bist_expect_o,
  input  logic             bist_done_i,
  input  logic [CNT_W-1:0] bist_count_i,
  output logic [TAP_W-1:0] tap0_o,
  output logic [TAP_W-1:0] tap1_o
);
  localparam int LANES = 2;

  logic                        rst_sync_n;
  cal_state_e                  state;
  logic [TAP_W-1:0]            tap_idx, orig_tap, low, high;
  logic                        found, rec, clr, pass;
  logic [LANES-1:0][TAP_W-1:0] lanes;

  dqs_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  dqs_cal_fsm #(.TAP_W(TAP_W), .CNT_W(CNT_W), .EXPECT(EXPECT)) i_fsm (
    .clk(clk), .rst_n(rst_sync_n), .cal_start_i(cal_start_i),
    .bist_done_i(bist_done_i), .tap_init_i(tap_init_i),
    .state_o(state), .tap_idx_o(tap_idx), .orig_tap_o(orig_tap),
    .expect_o(bist_expect_o)
  );

  assign rec  = (state == CAL_RUN) && bist_done_i;
  assign clr  = (state == CAL_IDLE) && cal_start_i;
  assign pass = (bist_count_i == CNT_W'(EXPECT));

  dqs_win_track #(.TAP_W(TAP_W)) i_track (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(clr), .rec_i(rec), .pass_i(pass),
    .tap_i(tap_idx), .found_o(found), .low_o(low), .high_o(high),
    .cnt_o(cal_pass_cnt_o)
  );

  dqs_tap_drive #(.TAP_W(TAP_W), .LANES(LANES)) i_drive (
    .clk(clk), .rst_n(rst_sync_n), .sweep_ld_i(state == CAL_SET),
    .final_ld_i(state == CAL_FINAL), .sweep_tap_i(tap_idx),
    .found_i(found), .low_i(low), .high_i(high), .orig_i(orig_tap),
    .lanes_o(lanes)
  );

  assign bist_start_o = (state == CAL_RUN);
  assign cal_done_o   = (state == CAL_DONE);
  assign cal_found_o  = found;
  assign tap0_o       = lanes[0];
  assign tap1_o       = lanes[1];
endmodule

// File: rtl/dqs_tap_calibrator_chk.sv
module dqs_tap_calibrator_chk #(
  parameter int TAP_W  = 6,
  parameter int CNT_W  = 8,
  parameter int EXPECT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cal_done_o,
  input logic             bist_start_o,
  input logic [CNT_W-1:0] bist_expect_o,
  input logic             bist_done_i,
  input logic [TAP_W-1:0] tap0_o,
  input logic [TAP_W-1:0] tap1_o
);
  a_r1_lanes_match: assert property (@(posedge clk) disable iff (!rst_n)
    bist_start_o |-> (tap0_o == tap1_o));

  a_r2_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_start_o && !bist_done_i) |=> bist_start_o);

  a_r2_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_start_o && bist_done_i) |=> !bist_start_o);

  a_r3_expect_value: assert property (@(posedge clk) disable iff (!rst_n)
    bist_start_o |-> (bist_expect_o == CNT_W'(EXPECT)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |=> !cal_done_o);

  a_r7_done_not_running: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |-> !bist_start_o);
endmodule

bind dqs_tap_calibrator dqs_tap_calibrator_chk #(
  .TAP_W(TAP_W), .CNT_W(CNT_W), .EXPECT(EXPECT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cal_done_o(cal_done_o),
  .bist_start_o(bist_start_o), .bist_expect_o(bist_expect_o),
  .bist_done_i(bist_done_i), .tap0_o(tap0_o), .tap1_o(tap1_o)
);

// File: tb/test_dqs_tap_calibrator.sv
module test_dqs_tap_calibrator;
  localparam int TAP_W = 6;
  localparam int CNT_W = 8;
  localparam int NTAP  = 64;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cal_start_i;
  logic [TAP_W-1:0] tap_init_i;
  logic             cal_done_o, cal_found_o, bist_start_o;
  logic [TAP_W:0]   cal_pass_cnt_o;
  logic [CNT_W-1:0] bist_expect_o, bist_count_i;
  logic             bist_done_i, resp_done, stray_done;
  logic [TAP_W-1:0] tap0_o, tap1_o;

  always #2 clk = ~clk;

  assign bist_done_i = resp_done | stray_done;

  dqs_tap_calibrator i_dqs_tap_calibrator (
    .clk(clk), .rst_n(rst_n), .cal_start_i(cal_start_i), .tap_init_i(tap_init_i),
    .cal_done_o(cal_done_o), .cal_found_o(cal_found_o), .cal_pass_cnt_o(cal_pass_cnt_o),
    .bist_start_o(bist_start_o), .bist_expect_o(bist_expect_o),
    .bist_done_i(bist_done_i), .bist_count_i(bist_count_i),
    .tap0_o(tap0_o), .tap1_o(tap1_o)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // self-test and delay line model
  logic [CNT_W-1:0] cnt_pat [NTAP];
  int wait_cnt = 0;

  always @(negedge clk) begin
    if (!bist_start_o) begin
      resp_done <= 1'b0;
      wait_cnt  <= int'(tap0_o) % 4;
    end else if (!resp_done) begin
      if (wait_cnt == 0) begin
        resp_done    <= 1'b1;
        bist_count_i <= cnt_pat[tap0_o];
      end else begin
        wait_cnt <= wait_cnt - 1;
      end
    end
  end

  // reference model, one sample per clock
  bit run_active = 0;
  bit finished   = 0;
  bit prev_start = 0;
  int exp_tap, m_cnt, m_first, m_last, m_orig, due;
  bit m_found, armed;

  always @(posedge clk) begin
    #1;
    if (rst_n && run_active) begin
      bit exp_done;
      exp_done = 1'b0;
      if (armed) begin
        due--;
        if (due == 0) begin
          exp_done = 1'b1;
          armed    = 1'b0;
        end
      end
      if (prev_start && bist_done_i) begin
        if (cnt_pat[exp_tap] == 8'd8) begin  // R3 exact match
          if (!m_found) m_first = exp_tap;
          m_last  = exp_tap;
          m_found = 1'b1;
          m_cnt++;
        end
        if (exp_tap == NTAP - 1) begin
          armed = 1'b1;
          due   = 2;
        end else begin
          exp_tap++;
        end
      end
      if (bist_start_o) begin
        chk(tap0_o == exp_tap[TAP_W-1:0], "R1 lane0 tap", int'(tap0_o), exp_tap);
        chk(tap1_o == exp_tap[TAP_W-1:0], "R1 lane1 tap", int'(tap1_o), exp_tap);
        chk(bist_expect_o == 8'd8, "R3 expected count", int'(bist_expect_o), 8);
      end
      if (prev_start && bist_done_i)
        chk(!bist_start_o, "R2 start release", int'(bist_start_o), 0);
      chk(cal_done_o == exp_done, "R7 done timing", int'(cal_done_o), int'(exp_done));
      if (exp_done) begin
        int fin;
        fin = m_found ? ((m_first + m_last) / 2) % NTAP : m_orig;
        chk(tap0_o == fin[TAP_W-1:0], m_found ? "R5 lane0 centre" : "R6 lane0 restore",
            int'(tap0_o), fin);
        chk(tap1_o == fin[TAP_W-1:0], m_found ? "R5 lane1 centre" : "R6 lane1 restore",
            int'(tap1_o), fin);
        chk(cal_found_o == m_found, "R4 found flag", int'(cal_found_o), int'(m_found));
        chk(int'(cal_pass_cnt_o) == m_cnt, "R4 pass count", int'(cal_pass_cnt_o), m_cnt);
        finished   = 1'b1;
        run_active = 1'b0;
      end
    end
    prev_start = bist_start_o;
  end

  task automatic set_pattern(input int kind);
    for (int t = 0; t < NTAP; t++) begin
      bit p;
      case (kind)
        0:       p = (t >= 20 && t <= 30);
        1:       p = 1'b0;
        2:       p = (t == 63);
        3:       p = (t == 0 || t == 40 || t == 63);
        4:       p = 1'b1;
        default: p = (t == 0);
      endcase
      cnt_pat[t] = p ? 8'd8 : ((t % 3 == 0) ? 8'd7 : ((t % 3 == 1) ? 8'd9 : 8'd0));
    end
  endtask

  task automatic run_cal(input int kind, input int init, input bit wiggle);
    set_pattern(kind);
    @(negedge clk);
    tap_init_i  = init[TAP_W-1:0];
    cal_start_i = 1'b1;
    exp_tap = 0; m_cnt = 0; m_first = 0; m_last = 0; m_found = 0;
    m_orig = init; armed = 0; due = 0; finished = 0; run_active = 1;
    @(negedge clk);
    cal_start_i = 1'b0;
    if (wiggle) begin
      repeat (20) @(negedge clk);
      tap_init_i = ~init[TAP_W-1:0];  // R6: must not matter
    end
    wait (finished);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cal_start_i = 1'b0; tap_init_i = '0;
    stray_done = 1'b0; bist_count_i = '0;
    for (int t = 0; t < NTAP; t++) cnt_pat[t] = '0;
    fork
      begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(cal_done_o == 0, "R9 done in reset", int'(cal_done_o), 0);
        chk(bist_start_o == 0, "R9 start in reset", int'(bist_start_o), 0);
        chk(cal_found_o == 0, "R9 found in reset", int'(cal_found_o), 0);
        chk(cal_pass_cnt_o == 0, "R9 count in reset", int'(cal_pass_cnt_o), 0);
        chk(bist_expect_o == 0, "R9 expect in reset", int'(bist_expect_o), 0);
        chk(tap0_o == 0 && tap1_o == 0, "R9 lanes in reset", int'(tap0_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        run_cal(0, 5, 0);    // R5 window 20..30 -> 25
        run_cal(1, 37, 1);   // R6 nothing passes, restore 37
        run_cal(2, 9, 0);    // R4 single pass at 63
        run_cal(3, 12, 0);   // R4 scattered passes, first 0 last 63
        run_cal(4, 3, 0);    // R4 all pass, count 64
        run_cal(5, 50, 0);   // R5 only tap 0 -> 0

        // R8 stray done while idle
        begin
          logic [TAP_W-1:0] t0, t1;
          t0 = tap0_o; t1 = tap1_o;
          @(negedge clk);
          bist_count_i = 8'd8;
          stray_done   = 1'b1;
          repeat (3) begin
            @(negedge clk);
            chk(cal_done_o == 0, "R8 no done on stray", int'(cal_done_o), 0);
            chk(bist_start_o == 0, "R8 no start on stray", int'(bist_start_o), 0);
          end
          stray_done = 1'b0;
          @(negedge clk);
          chk(tap0_o == t0, "R8 lane0 unchanged", int'(tap0_o), int'(t0));
          chk(tap1_o == t1, "R8 lane1 unchanged", int'(tap1_o), int'(t1));
        end
      end
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule